// File: doc/BRIEF.md
# Multi-Mode Timer Channel

This block is one 16-bit timer channel. A software start pulse launches it, a stop pulse halts it, and a live mode select decides how the counter begins and how it runs. Counting advances only on cycles where the count-clock strobe is high. The strobe comes from a prescaler outside the block. An external trigger pulse is used for capturing, for arming a one-shot, or for nothing, depending on the mode.

The five modes are:
- **Periodic down-count.** The counter loads on the first strobe after start.
- **Event down-count.** The counter loads at the start write itself.
- **Free up-count with capture.** The counter value is captured on a trigger.
- **Armed one-shot down-count.** Counting begins after a trigger.
- **Armed up-count measurement.** Counting begins after a trigger and is captured on the next trigger.

The channel holds its own data register. Software writes it through a write strobe, and the capture modes overwrite it with the counter value. The block reports:
- the live count,
- the data register,
- an enabled flag,
- a waiting-for-trigger flag,
- a registered one-cycle interrupt pulse.

The trigger input is taken as an already synchronised, edge-detected pulse.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset, the outputs are: cnt_o = 0xFFFF, data_o = 0x0000, en_o = 0, wait_o = 0, irq_o = 0.
- R2: The mode is set by mode_i. Mode 0 is periodic down-count, and values 5 to 7 act as mode 0. In this mode a start leaves cnt_o unchanged and sets en_o. The first strobe after the start loads cnt_o from data_o, and each later strobe subtracts one.
- R3: In modes 0 and 1, a strobe that takes the count from 1 to 0 raises irq_o for exactly the following cycle. A strobe that finds the count at 0 reloads it from data_o.
- R4: Mode 1 is event down-count. Here a start loads cnt_o from data_o on that same clock edge, and later strobes subtract one.
- R5: In mode 1 the trigger has no effect on cnt_o, en_o or data_o.
- R6: Mode 2 is capture up-count. The first strobe after a start sets cnt_o to 0, and each later strobe adds one.
- R7: In mode 2 with the channel enabled, a trigger copies cnt_o into data_o, pulses irq_o and sets cnt_o to 0. The trigger wins over a strobe in the same cycle.
- R8: Mode 3 is armed one-shot down-count, and mode 4 is armed up-count measurement. In modes 3 and 4, a start while en_o = 0 sets both en_o and wait_o. A start while en_o = 1 is ignored. While waiting, the count holds.
- R9: In mode 3, a trigger clears wait_o. The next strobe loads cnt_o from data_o, and later strobes subtract one. The strobe that leaves the count at 0 pulses irq_o, holds the count at 0 and sets wait_o again.
- R10: In mode 4, a trigger clears wait_o. The next strobe sets cnt_o to 0, and later strobes add one. A second trigger copies cnt_o into data_o, pulses irq_o and sets wait_o again.
- R11: A stop clears en_o and wait_o and freezes cnt_o. Stop wins over start. While disabled, strobes and triggers have no effect.
- R12: In modes 0 and 2, a start while already enabled re-arms the deferred load. The next strobe reloads the count: from data_o in mode 0, or to 0 in mode 2.
- R13: data_we_i writes data_wd_i into data_o on the next edge. A capture in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Software start pulse |
| stop_i | input | 1 | Software stop pulse |
| mode_i | input | 3 | Operating mode select |
| cnt_en_i | input | 1 | Count-clock strobe |
| trig_i | input | 1 | External trigger pulse |
| data_we_i | input | 1 | Data register write strobe |
| data_wd_i | input | 16 | Data register write value |
| cnt_o | output | 16 | Live counter value |
| data_o | output | 16 | Data register contents |
| en_o | output | 1 | Channel enabled |
| wait_o | output | 1 | Waiting for trigger |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situations to reach are the coincidences. One is a trigger that arrives together with a data write. Others are a start issued to an already armed one-shot, and the second trigger of the measurement mode after a count has run. The bench steers into each of these with directed sequences whose expected counts are written out by hand. It then runs a long random stream of starts, stops, strobes, triggers and writes in every mode, and compares each cycle against a behavioural model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MD_INTERVAL = 3'd0;
    localparam logic [MODE_W-1:0] MD_EVENT    = 3'd1;
    localparam logic [MODE_W-1:0] MD_CAPTURE  = 3'd2;
    localparam logic [MODE_W-1:0] MD_ONECNT   = 3'd3;
    localparam logic [MODE_W-1:0] MD_CAPONE   = 3'd4;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD_D,
        ACT_LOAD_Z,
        ACT_DEC,
        ACT_INC
    } act_e;

    typedef struct packed {
        act_e act;
        logic cap;
        logic irq;
    } cmd_t;

    function automatic logic is_armed_mode(logic [MODE_W-1:0] m);
        return (m == MD_ONECNT) || (m == MD_CAPONE);
    endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [MODE_W-1:0] mode,
    input  logic              strobe,
    input  logic              trig,
    input  logic              at_zero,
    input  logic              at_one,
    output cmd_t              cmd,
    output logic              en,
    output logic              waiting
);
    logic pend;
    logic en_n, wait_n, pend_n;

    always_comb begin
        cmd     = '{act: ACT_HOLD, cap: 1'b0, irq: 1'b0};
        en_n    = en;
        wait_n  = waiting;
        pend_n  = pend;
        if (stop) begin
            en_n   = 1'b0;
            wait_n = 1'b0;
            pend_n = 1'b0;
        end else if (start) begin
            if (is_armed_mode(mode)) begin
                if (!en) begin
                    en_n   = 1'b1;
                    wait_n = 1'b1;
                    pend_n = 1'b0;
                end
            end else if (mode == MD_EVENT) begin
                en_n    = 1'b1;
                wait_n  = 1'b0;
                pend_n  = 1'b0;
                cmd.act = ACT_LOAD_D;
            end else begin
                en_n   = 1'b1;
                wait_n = 1'b0;
                pend_n = 1'b1;
            end
        end else if (en) begin
            case (mode)
                MD_CAPTURE: begin
                    if (trig) begin
                        cmd.cap = 1'b1;
                        cmd.irq = 1'b1;
                        cmd.act = ACT_LOAD_Z;
                        pend_n  = 1'b0;
                    end else if (strobe) begin
                        cmd.act = pend ? ACT_LOAD_Z : ACT_INC;
                        pend_n  = 1'b0;
                    end
                end
                MD_ONECNT: begin
                    if (waiting) begin
                        if (trig) begin
                            wait_n = 1'b0;
                            pend_n = 1'b1;
                        end
                    end else if (strobe) begin
                        if (pend) begin
                            cmd.act = ACT_LOAD_D;
                            pend_n  = 1'b0;
                        end else if (at_zero || at_one) begin
                            cmd.act = at_one ? ACT_DEC : ACT_HOLD;
                            cmd.irq = 1'b1;
                            wait_n  = 1'b1;
                        end else begin
                            cmd.act = ACT_DEC;
                        end
                    end
                end
                MD_CAPONE: begin
                    if (waiting) begin
                        if (trig) begin
                            wait_n = 1'b0;
                            pend_n = 1'b1;
                        end
                    end else if (trig) begin
                        cmd.cap = 1'b1;
                        cmd.irq = 1'b1;
                        wait_n  = 1'b1;
                        pend_n  = 1'b0;
                    end else if (strobe) begin
                        cmd.act = pend ? ACT_LOAD_Z : ACT_INC;
                        pend_n  = 1'b0;
                    end
                end
                default: begin
                    if (strobe) begin
                        if (pend || at_zero) begin
                            cmd.act = ACT_LOAD_D;
                            pend_n  = 1'b0;
                        end else begin
                            cmd.act = ACT_DEC;
                            cmd.irq = at_one;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            waiting <= 1'b0;
            pend    <= 1'b0;
        end else begin
            en      <= en_n;
            waiting <= wait_n;
            pend    <= pend_n;
        end
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  cmd_t         cmd,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] cnt,
    output logic [W-1:0] data,
    output logic         irq,
    output logic         at_zero,
    output logic         at_one
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '1;
            data <= '0;
            irq  <= 1'b0;
        end else begin
            case (cmd.act)
                ACT_LOAD_D: cnt <= data;
                ACT_LOAD_Z: cnt <= '0;
                ACT_DEC:    cnt <= cnt - ONE;
                ACT_INC:    cnt <= cnt + ONE;
                default:    cnt <= cnt;
            endcase
            if (cmd.cap)
                data <= cnt;
            else if (we)
                data <= wd;
            irq <= cmd.irq;
        end
    end

    assign at_zero = (cnt == '0);
    assign at_one  = (cnt == ONE);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cnt_en_i,
    input  logic              trig_i,
    input  logic              data_we_i,
    input  logic [W-1:0]      data_wd_i,
    output logic [W-1:0]      cnt_o,
    output logic [W-1:0]      data_o,
    output logic              en_o,
    output logic              wait_o,
    output logic              irq_o
);
    cmd_t cmd;
    logic at_zero, at_one;

    tmr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .stop    (stop_i),
        .mode    (mode_i),
        .strobe  (cnt_en_i),
        .trig    (trig_i),
        .at_zero (at_zero),
        .at_one  (at_one),
        .cmd     (cmd),
        .en      (en_o),
        .waiting (wait_o)
    );

    tmr_count #(.W(W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .we      (data_we_i),
        .wd      (data_wd_i),
        .cnt     (cnt_o),
        .data    (data_o),
        .irq     (irq_o),
        .at_zero (at_zero),
        .at_one  (at_one)
    );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              stop_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              trig_i,
    input logic [W-1:0]      cnt_o,
    input logic [W-1:0]      data_o,
    input logic              en_o,
    input logic              wait_o,
    input logic              irq_o
);
    p_wait_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        wait_o |-> en_o);

    p_stop_clears_r11: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (!en_o && !wait_o));

    p_stop_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (cnt_o == $past(cnt_o)));

    p_event_load_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stop_i && mode_i == MD_EVENT) |=> (cnt_o == $past(data_o)));

    p_capture_copy_r7: assert property (@(posedge clk) disable iff (rst)
        (en_o && !stop_i && !start_i && mode_i == MD_CAPTURE && trig_i)
        |=> (data_o == $past(cnt_o) && irq_o && cnt_o == '0));

    p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wait_o && is_armed_mode(mode_i)) |=> (cnt_o == $past(cnt_o)));

    p_restart_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (en_o && start_i && !stop_i && is_armed_mode(mode_i))
        |=> (en_o && wait_o == $past(wait_o)));
endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stop_i  (stop_i),
    .mode_i  (mode_i),
    .trig_i  (trig_i),
    .cnt_o   (cnt_o),
    .data_o  (data_o),
    .en_o    (en_o),
    .wait_o  (wait_o),
    .irq_o   (irq_o)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, stop_i = 1'b0, cnt_en_i = 1'b0, trig_i = 1'b0, data_we_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] data_wd_i = 16'h0;
    logic [15:0] cnt_o, data_o;
    logic        en_o, wait_o, irq_o;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    int m_cnt, m_d, m_en, m_wt, m_pd, m_irq;

    always #10 clk = ~clk;

    tmr_channel uut (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .mode_i(mode_i),
        .cnt_en_i(cnt_en_i), .trig_i(trig_i), .data_we_i(data_we_i), .data_wd_i(data_wd_i),
        .cnt_o(cnt_o), .data_o(data_o), .en_o(en_o), .wait_o(wait_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_next(output int n_cnt, n_d, n_en, n_wt, n_pd, n_irq);
        bit armed = (mode_i == 3) || (mode_i == 4);
        bit cap = 0;
        n_cnt = m_cnt; n_d = m_d; n_en = m_en; n_wt = m_wt; n_pd = m_pd; n_irq = 0;
        if (rst) begin
            n_cnt = 16'hFFFF; n_d = 0; n_en = 0; n_wt = 0; n_pd = 0;
            return;
        end
        if (stop_i) begin
            n_en = 0; n_wt = 0; n_pd = 0;
        end else if (start_i) begin
            if (armed) begin
                if (m_en == 0) begin n_en = 1; n_wt = 1; n_pd = 0; end
            end else if (mode_i == 1) begin
                n_en = 1; n_wt = 0; n_pd = 0; n_cnt = m_d;
            end else begin
                n_en = 1; n_wt = 0; n_pd = 1;
            end
        end else if (m_en == 1) begin
            if (mode_i == 2) begin
                if (trig_i) begin cap = 1; n_irq = 1; n_cnt = 0; n_pd = 0; end
                else if (cnt_en_i) begin n_cnt = m_pd ? 0 : (m_cnt + 1) & 16'hFFFF; n_pd = 0; end
            end else if (mode_i == 3) begin
                if (m_wt == 1) begin
                    if (trig_i) begin n_wt = 0; n_pd = 1; end
                end else if (cnt_en_i) begin
                    if (m_pd == 1) begin n_cnt = m_d; n_pd = 0; end
                    else if (m_cnt <= 1) begin n_cnt = 0; n_irq = 1; n_wt = 1; end
                    else n_cnt = m_cnt - 1;
                end
            end else if (mode_i == 4) begin
                if (m_wt == 1) begin
                    if (trig_i) begin n_wt = 0; n_pd = 1; end
                end else if (trig_i) begin cap = 1; n_irq = 1; n_wt = 1; n_pd = 0; end
                else if (cnt_en_i) begin n_cnt = m_pd ? 0 : (m_cnt + 1) & 16'hFFFF; n_pd = 0; end
            end else begin
                if (cnt_en_i) begin
                    if (m_pd == 1 || m_cnt == 0) begin n_cnt = m_d; n_pd = 0; end
                    else begin n_cnt = m_cnt - 1; n_irq = (m_cnt == 1); end
                end
            end
        end
        if (cap) n_d = m_cnt;
        else if (data_we_i) n_d = data_wd_i;
    endtask

    task automatic cyc();
        int a, b, c, d, e, f;
        model_next(a, b, c, d, e, f);
        @(posedge clk);
        @(negedge clk);
        m_cnt = a; m_d = b; m_en = c; m_wt = d; m_pd = e; m_irq = f;
        checks++;
        if (cnt_o != m_cnt[15:0] || data_o != m_d[15:0] || en_o != m_en[0] ||
            wait_o != m_wt[0] || irq_o != m_irq[0]) begin
            errors++;
            $display("FAIL %s model: actual cnt=%h data=%h en=%b wait=%b irq=%b expected cnt=%h data=%h en=%0d wait=%0d irq=%0d",
                     cur_req, cnt_o, data_o, en_o, wait_o, irq_o, m_cnt[15:0], m_d[15:0], m_en, m_wt, m_irq);
        end
        start_i = 0; stop_i = 0; cnt_en_i = 0; trig_i = 0; data_we_i = 0;
    endtask

    task automatic step(input logic s, input logic p, input logic c, input logic t);
        start_i = s; stop_i = p; cnt_en_i = c; trig_i = t;
        cyc();
    endtask

    task automatic wr(input logic [15:0] v);
        data_we_i = 1; data_wd_i = v;
        cyc();
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_cnt = 16'hFFFF; m_d = 0; m_en = 0; m_wt = 0; m_pd = 0; m_irq = 0;
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        cyc();
        cur_req = "R1";
        chk("R1 cnt", cnt_o, 16'hFFFF); chk("R1 data", data_o, 0);
        chk("R1 en", en_o, 0); chk("R1 wait", wait_o, 0); chk("R1 irq", irq_o, 0);

        // periodic mode
        cur_req = "R13"; mode_i = 0; wr(16'd3); chk("R13 write", data_o, 3);
        cur_req = "R2";
        step(1,0,0,0); chk("R2 deferred", cnt_o, 16'hFFFF); chk("R2 en", en_o, 1);
        step(0,0,1,0); chk("R2 first load", cnt_o, 3);
        step(0,0,1,0); chk("R2 dec", cnt_o, 2);
        cur_req = "R3";
        step(0,0,1,0); chk("R3 one", cnt_o, 1); chk("R3 no irq", irq_o, 0);
        step(0,0,1,0); chk("R3 zero", cnt_o, 0); chk("R3 irq", irq_o, 1);
        step(0,0,0,0); chk("R3 irq pulse", irq_o, 0);
        step(0,0,1,0); chk("R3 reload", cnt_o, 3);
        step(0,0,1,0);
        cur_req = "R12";
        step(1,0,0,0); chk("R12 hold", cnt_o, 2);
        step(0,0,1,0); chk("R12 reload", cnt_o, 3);
        cur_req = "R11";
        step(0,1,0,0); chk("R11 en", en_o, 0);
        step(0,0,1,1); chk("R11 frozen", cnt_o, 3);
        step(1,1,0,0); chk("R11 stop wins", en_o, 0);

        // event mode
        cur_req = "R4"; mode_i = 1; wr(16'd5);
        step(1,0,0,0); chk("R4 immediate", cnt_o, 5);
        cur_req = "R5";
        step(0,0,0,1); chk("R5 trig cnt", cnt_o, 5); chk("R5 trig data", data_o, 5);
        cur_req = "R4";
        step(0,0,1,0); chk("R4 dec", cnt_o, 4);
        step(0,1,0,0);

        // capture mode
        cur_req = "R6"; mode_i = 2;
        step(1,0,0,0);
        step(0,0,1,0); chk("R6 zero load", cnt_o, 0);
        step(0,0,1,0); step(0,0,1,0); step(0,0,1,0); chk("R6 inc", cnt_o, 3);
        cur_req = "R7";
        step(0,0,1,1); chk("R7 data", data_o, 3); chk("R7 cnt", cnt_o, 0); chk("R7 irq", irq_o, 1);
        step(0,0,1,0); chk("R7 resumes", cnt_o, 1);
        cur_req = "R13";
        data_we_i = 1; data_wd_i = 16'h0077; step(0,0,0,1); chk("R13 capture wins", data_o, 1);
        cur_req = "R12";
        step(0,0,1,0); step(0,0,1,0); step(1,0,0,0); step(0,0,1,0); chk("R12 capture reload", cnt_o, 0);
        step(0,1,0,0);

        // armed one-shot
        cur_req = "R8"; mode_i = 3; wr(16'd2);
        step(1,0,0,0); chk("R8 en", en_o, 1); chk("R8 wait", wait_o, 1);
        step(0,0,1,0); chk("R8 hold", cnt_o, 0);
        step(1,0,0,0); chk("R8 start ignored", wait_o, 1);
        cur_req = "R9";
        step(0,0,0,1); chk("R9 armed", wait_o, 0);
        step(0,0,1,0); chk("R9 load", cnt_o, 2);
        step(0,0,1,0); chk("R9 dec", cnt_o, 1);
        step(0,0,1,0); chk("R9 end", cnt_o, 0); chk("R9 irq", irq_o, 1); chk("R9 rewait", wait_o, 1);
        step(0,0,1,0); chk("R9 stays", cnt_o, 0);
        step(0,1,0,0); chk("R11 wait clr", wait_o, 0);

        // armed measurement
        cur_req = "R10"; mode_i = 4;
        step(1,0,0,0); chk("R10 wait", wait_o, 1);
        step(0,0,0,1); chk("R10 armed", wait_o, 0);
        step(0,0,1,0); chk("R10 zero", cnt_o, 0);
        step(0,0,1,0); step(0,0,1,0); chk("R10 inc", cnt_o, 2);
        step(0,0,0,1); chk("R10 data", data_o, 2); chk("R10 irq", irq_o, 1); chk("R10 rewait", wait_o, 1);
        step(0,1,0,0);

        // random stream, model compared each cycle
        for (int blk = 0; blk < 12; blk++) begin
            step(0,1,0,0);
            mode_i = 3'(blk % 6);
            case (mode_i)
                3'd1: cur_req = "R4";
                3'd2: cur_req = "R7";
                3'd3: cur_req = "R9";
                3'd4: cur_req = "R10";
                default: cur_req = "R2";
            endcase
            for (int i = 0; i < 150; i++) begin
                start_i   = ($urandom_range(0, 24) == 0);
                stop_i    = ($urandom_range(0, 59) == 0);
                cnt_en_i  = ($urandom_range(0, 1) == 0);
                trig_i    = ($urandom_range(0, 7) == 0);
                data_we_i = ($urandom_range(0, 29) == 0);
                data_wd_i = 16'($urandom_range(0, 9));
                cyc();
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule